// File: doc/BRIEF.md
# Serial Status Word Shifter

This block reports a fixed status word to a host over a read-only three-wire serial port. The word holds one load-fault flag and one commanded-state flag per channel, plus three flags for the die and supply: an over-temperature warning, a thermal shutdown and a supply overvoltage. While the host holds select high, the shifter takes a fresh copy of these status inputs on every clock. When select goes low, it keeps the last copy and puts the first bit on the data line. Each later falling edge of the serial clock moves the next bit onto the line, so the host can sample on the rising edge.

The block runs in the system clock domain. Select and serial clock pass through a synchronizer of `SYNC_STAGES` flops, and the serial clock edges are found by comparing samples. So the serial clock must be several times slower than the system clock. The data line is shown as a data bit plus an output enable. Several such blocks can share one host line because each one drives it only while selected. When the whole word has been sent, the line stays at 1 until select goes high again.

With the default `NUM_CH = 4` the word is 11 bits long. The bits are numbered 1 to 11 in the order they leave the block.

Top module: `diag_word_shifter`

## Requirements
- R1: A frame has exactly 2*NUM_CH+3 data bits (11 at default). The host reads them with no gap: bit 1 after select falls, then one new bit after each serial clock falling edge.
- R2: While select is high, the snapshot is reloaded from the status inputs on every clock. Once select is low, later changes on the status inputs do not affect the frame being read.
- R3: Within SYNC_STAGES+1 clocks after select falls, and before any serial clock edge, sdoData shows bit 1 and sdoOe is 1.
- R4: sdoOe is 0 while select is high, which includes the state after reset.
- R5: Only a falling edge of serial clock moves to the next bit. A rising edge leaves sdoData unchanged.
- R6: Bits 1..NUM_CH are the load-fault flags for channel 0 upward, with 0 meaning a fault. Bits NUM_CH+1..2*NUM_CH are the commanded states for channel 0 upward, with 1 meaning on.
- R7: The last three bits are, in order, the over-temperature warning, the thermal shutdown and the overvoltage. Each reads 0 when its condition is present.
- R8: After the last bit, sdoData stays at 1 for any further serial clock falling edges until select goes high. The bit counter stops at the frame length and clears while select is high.
- R9: Serial clock edges that arrive while select is high are ignored. The next selection always starts at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Select from host, low selects this block |
| serClk | input | 1 | Serial clock from host, asynchronous |
| loadFault | input | NUM_CH | Per-channel load fault present (1 = fault) |
| chanOn | input | NUM_CH | Per-channel commanded state (1 = on) |
| tempWarn | input | 1 | Die above the warning temperature |
| thermShut | input | 1 | Thermal shutdown active |
| overVolt | input | 1 | Supply overvoltage present |
| sdoData | output | 1 | Serial data bit |
| sdoOe | output | 1 | Drive enable for the shared data line (0 = high impedance) |

## Verification
Some properties are checked on every cycle. The line is not driven while the synchronized select is high. Load and shift never happen in the same cycle. The snapshot does not change unless one of them happens. The counter stays at or below the frame length, clears after select goes high, and forces a 1 on the line once it reaches the frame length. The bench scenarios cover what these checks cannot show. They confirm that the bits come out in the right order and with the right polarity for each status pattern. They show that status changes made after selection are frozen out, that rising serial edges do not advance the frame, and that serial clock activity while deselected does not change where the next frame starts.

// File: rtl/diag_shift_pkg.sv
package diag_shift_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;       // take a snapshot of the status inputs
    logic shift;      // move to the next bit
    logic frameDone;  // all data bits have been sent
  } shiftCtl_t;
endpackage

// File: rtl/diag_shift_ctrl.sv
module diag_shift_ctrl
  import diag_shift_pkg::*;
#(
  parameter int FRAME_LEN   = 11,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             serClk,
  output shiftCtl_t        ctl,
  output logic [CNT_W-1:0] bitCnt
);
  logic [SYNC_STAGES-1:0] selChain;
  logic [SYNC_STAGES-1:0] clkChain;
  logic                   clkPrev;
  logic                   selHigh;
  logic                   fallSeen;
  logic                   done;

  assign selHigh  = selChain[SYNC_STAGES-1];
  assign fallSeen = clkPrev & ~clkChain[SYNC_STAGES-1];
  assign done     = (bitCnt == CNT_W'(FRAME_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selChain <= '1;
      clkChain <= '0;
      clkPrev  <= 1'b0;
      bitCnt   <= '0;
    end else begin
      selChain <= {selChain[SYNC_STAGES-2:0], selN};
      clkChain <= {clkChain[SYNC_STAGES-2:0], serClk};
      clkPrev  <= clkChain[SYNC_STAGES-1];
      if (selHigh)
        bitCnt <= '0;
      else if (fallSeen && !done)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load      = selHigh;
    ctl.shift     = !selHigh && fallSeen && !done;
    ctl.frameDone = done;
  end
endmodule

// File: rtl/diag_shift_dp.sv
module diag_shift_dp
  import diag_shift_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int FRAME_LEN = 2 * NUM_CH + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  shiftCtl_t            ctl,
  input  logic [NUM_CH-1:0]    loadFault,
  input  logic [NUM_CH-1:0]    chanOn,
  input  logic                 tempWarn,
  input  logic                 thermShut,
  input  logic                 overVolt,
  output logic [FRAME_LEN-1:0] shiftReg,
  output logic                 sdoData
);
  // The MSB of frameWord is bit 1, the first bit sent.
  logic [FRAME_LEN-1:0] frameWord;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign frameWord[FRAME_LEN-1-ch]        = ~loadFault[ch];
    assign frameWord[FRAME_LEN-1-NUM_CH-ch] = chanOn[ch];
  end
  assign frameWord[2] = ~tempWarn;
  assign frameWord[1] = ~thermShut;
  assign frameWord[0] = ~overVolt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '1;
    else if (ctl.load)
      shiftReg <= frameWord;
    else if (ctl.shift)
      shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
  end

  assign sdoData = ctl.frameDone ? 1'b1 : shiftReg[FRAME_LEN-1];
endmodule

// File: rtl/diag_word_shifter.sv
module diag_word_shifter
  import diag_shift_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              serClk,
  input  logic [NUM_CH-1:0] loadFault,
  input  logic [NUM_CH-1:0] chanOn,
  input  logic              tempWarn,
  input  logic              thermShut,
  input  logic              overVolt,
  output logic              sdoData,
  output logic              sdoOe
);
  localparam int FRAME_LEN = 2 * NUM_CH + 3;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  shiftCtl_t            ctl;
  logic [CNT_W-1:0]     bitCnt;
  logic [FRAME_LEN-1:0] shiftReg;

  diag_shift_ctrl #(.FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk),
    .ctl(ctl), .bitCnt(bitCnt)
  );

  diag_shift_dp #(.NUM_CH(NUM_CH), .FRAME_LEN(FRAME_LEN)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .loadFault(loadFault), .chanOn(chanOn),
    .tempWarn(tempWarn), .thermShut(thermShut), .overVolt(overVolt),
    .shiftReg(shiftReg), .sdoData(sdoData)
  );

  // The line is driven only while selected.
  assign sdoOe = !ctl.load;
endmodule

// File: rtl/diag_word_shifter_chk.sv
module diag_word_shifter_chk
  import diag_shift_pkg::*;
#(
  parameter int FRAME_LEN = 11,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input shiftCtl_t            ctl,
  input logic [CNT_W-1:0]     bitCnt,
  input logic [FRAME_LEN-1:0] shiftReg,
  input logic                 sdoData,
  input logic                 sdoOe
);
  assert_hiz_deselected_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !sdoOe);

  assert_frozen_snapshot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.shift) |=> $stable(shiftReg));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.shift}));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_LEN));

  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (bitCnt == '0));

  assert_idle_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && bitCnt == CNT_W'(FRAME_LEN)) |-> sdoData);
endmodule

bind diag_word_shifter diag_word_shifter_chk #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .bitCnt(bitCnt),
  .shiftReg(shiftReg), .sdoData(sdoData), .sdoOe(sdoOe)
);

// File: tb/diag_word_shifter_test.sv
module diag_word_shifter_test;
  localparam int NCH   = 4;
  localparam int FLEN  = 2 * NCH + 3;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic serClk = 1'b0;
  logic [NCH-1:0] loadFault = '0;
  logic [NCH-1:0] chanOn = '0;
  logic tempWarn = 1'b0, thermShut = 1'b0, overVolt = 1'b0;
  logic sdoData, sdoOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  diag_word_shifter #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk),
    .loadFault(loadFault), .chanOn(chanOn),
    .tempWarn(tempWarn), .thermShut(thermShut), .overVolt(overVolt),
    .sdoData(sdoData), .sdoOe(sdoOe)
  );

  // Expected frame, MSB is bit 1 (R6, R7 encoding).
  function automatic logic [FLEN-1:0] expFrame(input logic [NCH-1:0] lf, input logic [NCH-1:0] on,
                                               input logic tw, input logic ts, input logic ov);
    logic [FLEN-1:0] f;
    for (int c = 0; c < NCH; c++) begin
      f[FLEN-1-c]     = ~lf[c];
      f[FLEN-1-NCH-c] = on[c];
    end
    f[2] = ~tw;
    f[1] = ~ts;
    f[0] = ~ov;
    return f;
  endfunction

  function automatic string bitReq(input int idx);
    if (idx < 2 * NCH) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Wait, then sample away from the rising edge.
  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setStatus(input logic [NCH-1:0] lf, input logic [NCH-1:0] on,
                           input logic tw, input logic ts, input logic ov);
    loadFault = lf; chanOn = on; tempWarn = tw; thermShut = ts; overVolt = ov;
  endtask

  task automatic readFrame(input logic [NCH-1:0] lf, input logic [NCH-1:0] on,
                           input logic tw, input logic ts, input logic ov, input int extra,
                           input bit toggleIdle);
    logic [FLEN-1:0] exp;
    exp = expFrame(lf, on, tw, ts, ov);
    // A different earlier value that must be overwritten (R2).
    setStatus(~lf, ~on, ~tw, ~ts, ~ov);
    settle(3);
    if (toggleIdle) begin
      for (int t = 0; t < 3; t++) begin  // R9: ignored while deselected
        serClk = 1'b1; settle(SETTLE);
        serClk = 1'b0; settle(SETTLE);
      end
    end
    setStatus(lf, on, tw, ts, ov);
    settle(3);
    chk("R4", sdoOe, 1'b0, "oe before select");
    selN = 1'b0;
    settle(SETTLE);
    chk("R3", sdoOe, 1'b1, "oe after select");
    chk("R3", sdoData, exp[FLEN-1], "bit 1 before clocks");
    // Status changes after selection must not appear (R2).
    setStatus($urandom, $urandom, $urandom, $urandom, $urandom);
    for (int k = 1; k < FLEN; k++) begin
      serClk = 1'b1; settle(SETTLE);
      chk("R5", sdoData, exp[FLEN-k], "rising edge held bit");
      serClk = 1'b0; settle(SETTLE);
      chk(bitReq(k), sdoData, exp[FLEN-1-k], $sformatf("bit %0d", k + 1));
    end
    for (int e = 0; e < extra; e++) begin
      serClk = 1'b1; settle(SETTLE);
      serClk = 1'b0; settle(SETTLE);
      chk("R8", sdoData, 1'b1, "idle after frame");
      chk("R1", sdoOe, 1'b1, "still driving after frame");
    end
    selN = 1'b1;
    settle(SETTLE);
    chk("R4", sdoOe, 1'b0, "oe after deselect");
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    settle(3);
    chk("R4", sdoOe, 1'b0, "reset oe");
    rstN = 1'b1;
    settle(3);
    chk("R4", sdoOe, 1'b0, "oe after reset release");
    // Directed corner cases.
    readFrame('0, '0, 1'b0, 1'b0, 1'b0, 3, 1'b0);
    readFrame('1, '1, 1'b1, 1'b1, 1'b1, 2, 1'b1);
    readFrame(4'b0001, 4'b1000, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    readFrame(4'b1000, 4'b0001, 1'b0, 1'b1, 1'b1, 0, 1'b1);
    // Random frames.
    for (int r = 0; r < 20; r++) begin
      readFrame($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom_range(0, 3)), 1'($urandom));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule